// File: doc/BRIEF.md
# Polarity-Configurable PWM Timer

This block generates one pulse-width modulated output from a period count and a duty count, both measured in ticks of a fixed clock divider. A host writes the counts and a control word through a small synchronous register port. The control word chooses the level driven during the duty part of each period and, separately, the level driven while the channel is stopped. The output is left-aligned: every period opens with its duty part.

The channel runs only when the control word holds the correct combination: the enable and free-running bits set, and the centre-alignment and low-power bits clear. Any other combination holds the counter and divider at zero and drives the idle level. When the channel starts, the first period takes the programmed counts at once. After that, new counts wait in shadow registers until the current period ends, so the waveform never carries a partial period.

Register map (word addresses): 0 holds the period count, 1 holds the duty count, 2 holds the control word. Control word bits: 0 enable, 1 free-running, 3 duty level (1 means high), 4 idle level (1 means high), 5 centre-align request (must be 0 for the channel to run), 8 low-power request (must be 0 for the channel to run). Reads are combinational from the address.

Top module: `pwm_tmr_top`

## Requirements
- R1: After reset, every register reads 0 and the output is low.
- R2: The period and duty registers read back exactly the value written. The control register reads back bits 0, 1, 3, 4, 5 and 8 as written, and every other bit reads 0.
- R3: The channel runs only when control bits 0 and 1 are both 1 and bits 5 and 8 are both 0. Any other combination leaves the output at the idle level.
- R4: While running with period P and duty D, the output is at the duty level while the count is below D and at the opposite level for the rest of the period. The count starts at 0 in each period.
- R5: Control bit 3 sets the duty level: 1 drives the duty part high, 0 drives it low.
- R6: While the channel is not running, the output equals control bit 4.
- R7: If D is at least P, the output stays at the duty level for the whole period. If D is 0, the output stays at the opposite level.
- R8: Period and duty values written while the channel runs take effect at the first sample after the current period ends.
- R9: A period of 0 while running drives the idle level.
- R10: The output returns to the idle level as soon as the control register stops the channel. A later start loads the counts directly and begins again from count 0, with the first counted cycle following the cycle in which the control write lands.
- R11: The count advances once every PRESCALE clock cycles, so each count value lasts PRESCALE cycles. It wraps to 0 after P-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write strobe, captured on the rising edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a period or duty write that lands in the middle of a running period. The waveform would show no change until the boundary, and only at the boundary would the new counts appear. The bench therefore starts a short period and then, in the next two cycles, writes a longer period and a larger duty. It predicts, sample by sample, that the old counts hold for exactly one full period before the new ones appear at count 0. A separate stop-and-restart sequence in mid-period checks that the restart begins from count 0 and not from where the count left off.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

   // word addresses of the register port
   localparam int ADDR_PERIOD = 0;
   localparam int ADDR_DUTY   = 1;
   localparam int ADDR_CTRL   = 2;

   // control word bit positions (software visible)
   localparam int CB_EN      = 0;
   localparam int CB_CONT    = 1;
   localparam int CB_DUTY_HI = 3;
   localparam int CB_IDLE_HI = 4;
   localparam int CB_CENTER  = 5;
   localparam int CB_LOWPWR  = 8;
   localparam int CTRL_MIN_W = CB_LOWPWR + 1;

   typedef struct packed {
      logic lowpwr;
      logic center;
      logic idle_hi;
      logic duty_hi;
      logic cont;
      logic en;
   } ctrl_t;

   // run condition: every required bit in its required state
   function automatic logic ctrl_runs(input ctrl_t c);
      return c.en & c.cont & ~c.center & ~c.lowpwr;
   endfunction

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
   import pwm_tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  per_q,
   output logic [CNT_W-1:0]  duty_q,
   output ctrl_t             ctrl_q
);

   localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(ADDR_PERIOD);
   localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(ADDR_DUTY);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q  <= '0;
         duty_q <= '0;
         ctrl_q <= '0;
      end else if (we) begin
         if (addr == A_PER)  per_q  <= wdata[CNT_W-1:0];
         if (addr == A_DUTY) duty_q <= wdata[CNT_W-1:0];
         if (addr == A_CTRL) begin
            ctrl_q.en      <= wdata[CB_EN];
            ctrl_q.cont    <= wdata[CB_CONT];
            ctrl_q.duty_hi <= wdata[CB_DUTY_HI];
            ctrl_q.idle_hi <= wdata[CB_IDLE_HI];
            ctrl_q.center  <= wdata[CB_CENTER];
            ctrl_q.lowpwr  <= wdata[CB_LOWPWR];
         end
      end
   end

   logic [DATA_W-1:0] ctrl_rd;
   always_comb begin
      ctrl_rd             = '0;
      ctrl_rd[CB_EN]      = ctrl_q.en;
      ctrl_rd[CB_CONT]    = ctrl_q.cont;
      ctrl_rd[CB_DUTY_HI] = ctrl_q.duty_hi;
      ctrl_rd[CB_IDLE_HI] = ctrl_q.idle_hi;
      ctrl_rd[CB_CENTER]  = ctrl_q.center;
      ctrl_rd[CB_LOWPWR]  = ctrl_q.lowpwr;
   end

   always_comb begin
      if (addr == A_PER)       rdata = DATA_W'(per_q);
      else if (addr == A_DUTY) rdata = DATA_W'(duty_q);
      else if (addr == A_CTRL) rdata = ctrl_rd;
      else                     rdata = '0;
   end

endmodule

// File: rtl/pwm_tmr_tick.sv
module pwm_tmr_tick #(
   parameter int PRESCALE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   generate
      if (PRESCALE == 1) begin : g_bypass
         assign tick = ~clr;
      end else begin : g_div
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr || pre_q == LAST) pre_q <= '0;
            else                                pre_q <= pre_q + 1'b1;
         end
         assign tick = ~clr && (pre_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] per_in,
   input  logic [CNT_W-1:0] duty_in,
   input  logic             duty_hi,
   input  logic             idle_hi,
   output logic             pwm_out,
   output logic             started_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] act_per_o,
   output logic [CNT_W-1:0] act_duty_o
);

   logic             started_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] act_per_q;
   logic [CNT_W-1:0] act_duty_q;
   logic             at_end;

   // a zero period counts as a boundary on every tick so a new value can load
   assign at_end = (act_per_q == '0) || (cnt_q >= act_per_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q  <= 1'b0;
         cnt_q      <= '0;
         act_per_q  <= '0;
         act_duty_q <= '0;
      end else if (!run) begin
         started_q <= 1'b0;
         cnt_q     <= '0;
      end else if (!started_q) begin
         started_q  <= 1'b1;
         cnt_q      <= '0;
         act_per_q  <= per_in;
         act_duty_q <= duty_in;
      end else if (tick) begin
         if (at_end) begin
            cnt_q      <= '0;
            act_per_q  <= per_in;
            act_duty_q <= duty_in;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (!run || !started_q || act_per_q == '0) pwm_out = idle_hi;
      else if (cnt_q < act_duty_q)                pwm_out = duty_hi;
      else                                        pwm_out = ~duty_hi;
   end

   assign started_o  = started_q;
   assign cnt_o      = cnt_q;
   assign act_per_o  = act_per_q;
   assign act_duty_o = act_duty_q;

endmodule

// File: rtl/pwm_tmr_top.sv
module pwm_tmr_top
   import pwm_tmr_pkg::*;
#(
   parameter int PRESCALE = 2,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter int ADDR_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              pwm_out
);

   initial begin : elab_chk
      assert (PRESCALE >= 1) else $error("PRESCALE must be at least 1");
      assert (CNT_W >= 2 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      assert (DATA_W >= CTRL_MIN_W) else $error("DATA_W too narrow for control word");
      assert (ADDR_W >= 2) else $error("ADDR_W too narrow for register map");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] per_reg;
   logic [CNT_W-1:0] duty_reg;
   logic             run;
   logic             tick;
   logic             started;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_per;
   logic [CNT_W-1:0] act_duty;

   pwm_tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (reg_addr),
      .we     (reg_we),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .per_q  (per_reg),
      .duty_q (duty_reg),
      .ctrl_q (ctrl)
   );

   assign run = ctrl_runs(ctrl);

   pwm_tmr_tick #(.PRESCALE(PRESCALE)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~(run & started)),
      .tick  (tick)
   );

   pwm_tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .tick       (tick),
      .per_in     (per_reg),
      .duty_in    (duty_reg),
      .duty_hi    (ctrl.duty_hi),
      .idle_hi    (ctrl.idle_hi),
      .pwm_out    (pwm_out),
      .started_o  (started),
      .cnt_o      (cnt),
      .act_per_o  (act_per),
      .act_duty_o (act_duty)
   );

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             started,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_per,
   input logic [CNT_W-1:0] act_duty,
   input logic             duty_hi,
   input logic             idle_hi,
   input logic             pwm_out
);

   p_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> pwm_out == idle_hi);

   p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (started && act_per != '0) |-> cnt < act_per);

   p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run && started && !tick) |=> (!run || $stable(cnt)));

   p_reload_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_per) |-> cnt == '0);

   p_full_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && started && act_per != '0 && act_duty >= act_per) |-> pwm_out == duty_hi);

   p_zero_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && started && act_per != '0 && act_duty == '0) |-> pwm_out == !duty_hi);

   p_zero_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && started && act_per == '0) |-> pwm_out == idle_hi);

   p_start_at_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(started) |-> cnt == '0);

endmodule

bind pwm_tmr_top pwm_tmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .tick     (tick),
   .started  (started),
   .cnt      (cnt),
   .act_per  (act_per),
   .act_duty (act_duty),
   .duty_hi  (ctrl.duty_hi),
   .idle_hi  (ctrl.idle_hi),
   .pwm_out  (pwm_out)
);

// File: tb/tb_pwm_tmr_top.sv
module tb_pwm_tmr_top;

   localparam int P = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  reg_addr;
   logic        reg_we;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        pwm_out;

   always #4 clk = ~clk;   // 125 MHz

   pwm_tmr_top #(.PRESCALE(P)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pwm_out   (pwm_out)
   );

   typedef struct {
      bit exp;
      int req;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad   = 0;

   // monitor: one expected output level per falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         total++;
         if (pwm_out !== it.exp) begin
            bad++;
            $display("FAIL R%0d pwm_out actual=%b expected=%b at %0t", it.req, pwm_out, it.exp, $time);
         end
      end
   end

   // driver helpers, each called at a falling edge plus 1
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk); #1;
      reg_we    = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input int req);
      reg_addr = a;
      #1;
      total++;
      if (reg_rdata !== exp) begin
         bad++;
         $display("FAIL R%0d read addr %0d actual=%h expected=%h", req, a, reg_rdata, exp);
      end
   endtask

   task automatic push_const(input bit v, input int n, input int req);
      for (int i = 0; i < n; i++) begin
         item_t it;
         it.exp = v;
         it.req = req;
         q.push_back(it);
      end
   endtask

   // expected left-aligned waveform, sample k counted from the first running cycle
   task automatic push_seg(input int per, input int duty, input bit dl, input int n, input int req);
      for (int k = 0; k < n; k++) begin
         item_t it;
         int c;
         c = (k / P) % per;
         it.exp = (c < duty) ? dl : ~dl;
         it.req = req;
         q.push_back(it);
      end
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk); #1;
   endtask

   initial begin
      #(8 * 20000);
      total++;
      bad++;
      $display("FAIL watchdog expired, pending=%0d", q.size());
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      reg_we    = 1'b0;
      reg_addr  = 2'd0;
      reg_wdata = 32'd0;
      repeat (3) @(negedge clk);
      #1;
      rst_n = 1'b1;
      // R1: reset state
      total++;
      if (pwm_out !== 1'b0) begin
         bad++;
         $display("FAIL R1 pwm_out actual=%b expected=0", pwm_out);
      end
      rd_chk(2'd0, 32'h0, 1);
      rd_chk(2'd1, 32'h0, 1);
      rd_chk(2'd2, 32'h0, 1);
      @(negedge clk); #1;

      // R2: readback of all registers
      wr(2'd0, 32'hDEAD_BEEF);
      wr(2'd1, 32'h1234_5678);
      rd_chk(2'd0, 32'hDEAD_BEEF, 2);
      rd_chk(2'd1, 32'h1234_5678, 2);
      @(negedge clk); #1;
      wr(2'd2, 32'hFFFF_FFFF);
      rd_chk(2'd2, 32'h0000_013B, 2);
      @(negedge clk); #1;
      // R3: centre and low-power set, idle level high
      push_const(1'b1, 6, 3);
      drain();

      // R3: incomplete run combinations stay idle (low)
      wr(2'd2, 32'h0000_0009);  // enable, duty high, no free-run
      push_const(1'b0, 6, 3);
      drain();
      wr(2'd2, 32'h0000_010B);  // low-power set
      push_const(1'b0, 6, 3);
      drain();
      wr(2'd2, 32'h0000_002B);  // centre set
      push_const(1'b0, 6, 3);
      drain();
      wr(2'd2, 32'h0000_000A);  // free-run without enable
      push_const(1'b0, 6, 3);
      drain();

      // R4, R11: basic waveform, duty high
      wr(2'd0, 32'd5);
      wr(2'd1, 32'd2);
      wr(2'd2, 32'h0000_000B);
      push_seg(5, 2, 1'b1, 30, 4);
      drain();
      wr(2'd2, 32'h0000_0000);
      push_const(1'b0, 4, 10);   // R10 stop goes idle
      drain();

      // R6: idle level high while stopped
      wr(2'd2, 32'h0000_0010);
      push_const(1'b1, 4, 6);
      drain();
      // R5: duty level low
      wr(2'd0, 32'd4);
      wr(2'd1, 32'd1);
      wr(2'd2, 32'h0000_0013);
      push_seg(4, 1, 1'b0, 24, 5);
      drain();
      wr(2'd2, 32'h0000_0010);
      push_const(1'b1, 4, 6);
      drain();

      // R7: duty above period
      wr(2'd2, 32'h0000_0000);
      wr(2'd0, 32'd3);
      wr(2'd1, 32'd7);
      wr(2'd2, 32'h0000_000B);
      push_const(1'b1, 18, 7);
      drain();
      wr(2'd2, 32'h0000_0000);
      push_const(1'b0, 3, 6);
      drain();
      // R7: duty zero, duty level low, idle low
      wr(2'd1, 32'd0);
      wr(2'd2, 32'h0000_0003);
      push_const(1'b1, 18, 7);
      drain();
      wr(2'd2, 32'h0000_0000);
      push_const(1'b0, 3, 6);
      drain();

      // R8: shadowed update written in the first period
      wr(2'd0, 32'd4);
      wr(2'd1, 32'd2);
      wr(2'd2, 32'h0000_000B);
      push_seg(4, 2, 1'b1, 8, 8);
      push_seg(6, 5, 1'b1, 24, 8);
      wr(2'd0, 32'd6);
      wr(2'd1, 32'd5);
      drain();
      wr(2'd2, 32'h0000_0000);
      push_const(1'b0, 3, 10);
      drain();

      // R9: zero period with idle high, duty low
      wr(2'd0, 32'd0);
      wr(2'd1, 32'd3);
      wr(2'd2, 32'h0000_0013);
      push_const(1'b1, 12, 9);
      drain();
      wr(2'd2, 32'h0000_0000);
      push_const(1'b0, 3, 6);
      drain();

      // R10: stop in mid-period, restart from count 0
      wr(2'd0, 32'd5);
      wr(2'd1, 32'd2);
      wr(2'd2, 32'h0000_000B);
      push_seg(5, 2, 1'b1, 7, 10);
      drain();
      wr(2'd2, 32'h0000_0000);
      push_const(1'b0, 3, 10);
      drain();
      wr(2'd2, 32'h0000_000B);
      push_seg(5, 2, 1'b1, 20, 10);
      drain();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule